// File: doc/BRIEF.md
# Separate-Port Burst-of-Two DDR SRAM

This block models a synchronous memory with an independent read port and write port. Each port moves two data beats per access. One period of the external K clock becomes two cycles of a single fast clock. In the phase-0 cycle the next rising edge stands for the K edge. In the phase-1 cycle it stands for the K# edge. The current phase is brought out on `k_phase` so that the driving logic can line its inputs up with it.

A write is launched on a K edge and sends its first beat on that edge. The address and the second beat follow on the next K# edge. An input demultiplexer joins the two beats into one double-width word and stores it in a single array operation. Active-low byte enables mask each byte of each beat. A read is launched on a K edge and fetches one double-width word. An output multiplexer then sends the low half after the next K edge and the high half after the K# edge that follows it. A read and a write may be issued in the same K period. A read sees a write to the same address issued in the same K period or the one before it.

The address is one bit narrower than the beat depth, because each array location holds two beats.

Top module: `sep_io_b2_ram`

## Requirements
- R1: `k_phase` is 0 in the first cycle after reset and toggles on every clock edge. A value of 0 means the coming edge is a K edge.
- R2: `rd_n` and `rd_addr` are sampled only on K edges, and `rd_n` is active low. A low `rd_n` during a phase-1 cycle is ignored.
- R3: For a read sampled on K edge n, `dout` carries the low beat (word bits [BEAT_W-1:0]) after edge n+2. It carries the high beat after edge n+3.
- R4: `dout_valid` is high for exactly the two beat cycles of each read. Outside them `dout_valid` is low and `dout` is zero. Both are low after reset.
- R5: `wr_n` is active low and is sampled on K edges only. The first beat and its byte enables are captured with the command. The write address, the second beat and its byte enables are captured on the following K# edge. A `wr_addr` value presented with the command is ignored.
- R6: The two beats of a write are stored as one word at a word address of ADDR_W bits: the first beat in the low half, the second in the high half. A later read returns both beats unchanged.
- R7: `bw_n` bit i is active low and enables bits [8i+7:8i] of its beat. Masked bytes keep their old contents.
- R8: A read and a write in the same K period, to different addresses, both take effect.
- R9: A read in the same K period as a write, or in the next K period, to the same address, returns the newly written data.
- R10: Reads issued in consecutive K periods give an unbroken beat stream with `dout_valid` held high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast clock: two cycles per K period |
| rst_n | input | 1 | Asynchronous active-low reset |
| k_phase | output | 1 | 0: the next edge is a K edge; 1: the next edge is a K# edge |
| rd_n | input | 1 | Read request, active low, sampled on K edges |
| rd_addr | input | ADDR_W | Read word address |
| wr_n | input | 1 | Write request, active low, sampled on K edges |
| wr_addr | input | ADDR_W | Write word address, sampled on the K# edge after the request |
| din | input | BYTE_W*BYTES | Write beat |
| bw_n | input | BYTES | Byte write enables of the current beat, active low |
| dout | output | BYTE_W*BYTES | Read beat, zero when idle |
| dout_valid | output | 1 | High while `dout` carries a read beat |

## Verification
The assertions assume that reset is applied for at least one edge. They assume that the masked-write check only looks at locations that have been written once, so their contents are defined. The read-start assertion looks three edges back, to the sampling K edge, so it expects no read to complete within three edges of reset release. The stimulus meets these conditions. It releases reset at a phase-0 negative edge and fills every word before any read. It drives every input at negative edges in step with `k_phase`. It also drives `rd_n` and `wr_n` low during every phase-1 cycle and sets `wr_addr` to a wrong value during every phase-0 cycle, so that each ignored input is tested all the time.

// File: rtl/b2_ram_pkg.sv
package b2_ram_pkg;
  typedef enum logic {
    PH_K  = 1'b0,
    PH_KB = 1'b1
  } kphase_e;
endpackage

// File: rtl/b2_phase_gen.sv
module b2_phase_gen
  import b2_ram_pkg::*;
(
  input  logic    clk,
  input  logic    rst_n,
  output kphase_e phase
);
  kphase_e phase_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) phase_q <= PH_K;
    else        phase_q <= (phase_q == PH_K) ? PH_KB : PH_K;
  end

  assign phase = phase_q;
endmodule

// File: rtl/b2_write_demux.sv
module b2_write_demux
  import b2_ram_pkg::*;
#(
  parameter int ADDR_W = 3,
  parameter int BYTE_W = 8,
  parameter int BYTES  = 2,
  localparam int BEAT_W = BYTE_W * BYTES
) (
  input  logic                clk,
  input  logic                rst_n,
  input  kphase_e             phase,
  input  logic                wr_n,
  input  logic [ADDR_W-1:0]   wr_addr,
  input  logic [BEAT_W-1:0]   din,
  input  logic [BYTES-1:0]    bw_n,
  output logic                wr_stb,
  output logic [ADDR_W-1:0]   wr_word_addr,
  output logic [2*BEAT_W-1:0] wr_word,
  output logic [2*BYTES-1:0]  wr_be_n
);
  logic              cmd_pend;
  logic [BEAT_W-1:0] beat0_q;
  logic [BYTES-1:0]  be0_q;

  // K edge: request and first beat; K# edge: second beat joins it
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cmd_pend <= 1'b0;
      beat0_q  <= '0;
      be0_q    <= '1;
    end else if (phase == PH_K) begin
      cmd_pend <= !wr_n;
      beat0_q  <= din;
      be0_q    <= bw_n;
    end else begin
      cmd_pend <= 1'b0;
    end
  end

  assign wr_stb       = cmd_pend && (phase == PH_KB);
  assign wr_word_addr = wr_addr;
  assign wr_word      = {din, beat0_q};
  assign wr_be_n      = {bw_n, be0_q};

  // R5: an array write is always backed by a K-edge request one edge earlier
  assert_write_after_cmd_R5: assert property (@(posedge clk) disable iff (!rst_n)
    wr_stb |-> ($past(!wr_n) && ($past(phase) == PH_K)));
endmodule

// File: rtl/b2_array.sv
module b2_array #(
  parameter int ADDR_W = 3,
  parameter int BYTE_W = 8,
  parameter int BYTES  = 2,
  localparam int WORD_W = 2 * BYTE_W * BYTES,
  localparam int LANES  = 2 * BYTES,
  localparam int DEPTH  = 1 << ADDR_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we,
  input  logic [ADDR_W-1:0] waddr,
  input  logic [WORD_W-1:0] wdata,
  input  logic [LANES-1:0]  wbe_n,
  input  logic [ADDR_W-1:0] raddr,
  output logic [WORD_W-1:0] rdata
);
  logic [WORD_W-1:0] mem [DEPTH];

  function automatic logic [WORD_W-1:0] lane_merge(
    input logic [WORD_W-1:0] old_w,
    input logic [WORD_W-1:0] new_w,
    input logic [LANES-1:0]  be_n);
    logic [WORD_W-1:0] res;
    res = old_w;
    for (int i = 0; i < LANES; i++)
      if (!be_n[i]) res[i*BYTE_W +: BYTE_W] = new_w[i*BYTE_W +: BYTE_W];
    return res;
  endfunction

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= lane_merge(mem[waddr], wdata, wbe_n);
  end

  assign rdata = mem[raddr];

  // R7: a write with every lane masked leaves the word untouched
  assert_masked_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (we && (&wbe_n)) |=> (mem[$past(waddr)] === $past(mem[waddr])));
endmodule

// File: rtl/b2_read_mux.sv
module b2_read_mux
  import b2_ram_pkg::*;
#(
  parameter int ADDR_W = 3,
  parameter int BYTE_W = 8,
  parameter int BYTES  = 2,
  localparam int BEAT_W = BYTE_W * BYTES
) (
  input  logic                clk,
  input  logic                rst_n,
  input  kphase_e             phase,
  input  logic                rd_n,
  input  logic [ADDR_W-1:0]   rd_addr,
  output logic [ADDR_W-1:0]   arr_addr,
  input  logic [2*BEAT_W-1:0] arr_word,
  output logic [BEAT_W-1:0]   dout,
  output logic                dout_valid
);
  logic              cmd_v;
  logic [ADDR_W-1:0] cmd_a;
  logic [BEAT_W-1:0] hold_hi;
  logic              hi_pend;

  function automatic logic [BEAT_W-1:0] beat_of(input logic [2*BEAT_W-1:0] w,
                                                input logic sel);
    return sel ? w[2*BEAT_W-1:BEAT_W] : w[BEAT_W-1:0];
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cmd_v      <= 1'b0;
      cmd_a      <= '0;
      hold_hi    <= '0;
      hi_pend    <= 1'b0;
      dout       <= '0;
      dout_valid <= 1'b0;
    end else if (phase == PH_K) begin
      cmd_v <= !rd_n;
      cmd_a <= rd_addr;
      if (cmd_v) begin
        dout       <= beat_of(arr_word, 1'b0);
        hold_hi    <= beat_of(arr_word, 1'b1);
        hi_pend    <= 1'b1;
        dout_valid <= 1'b1;
      end else begin
        dout       <= '0;
        hi_pend    <= 1'b0;
        dout_valid <= 1'b0;
      end
    end else begin
      dout       <= hi_pend ? hold_hi : '0;
      dout_valid <= hi_pend;
      hi_pend    <= 1'b0;
    end
  end

  assign arr_addr = cmd_a;

  // R3: a beat stream starts three edges after a low rd_n seen on a K edge
  assert_valid_start_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(dout_valid) |-> ($past(!rd_n, 3) && ($past(phase, 3) == PH_K)));

  // R4: the low beat is always followed by the high beat
  assert_valid_pair_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (dout_valid && (phase == PH_KB)) |=> dout_valid);

  // R4: idle output is zero
  assert_idle_zero_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !dout_valid |-> (dout == '0));
endmodule

// File: rtl/sep_io_b2_ram.sv
module sep_io_b2_ram
  import b2_ram_pkg::*;
#(
  parameter int ADDR_W = 3,
  parameter int BYTE_W = 8,
  parameter int BYTES  = 2,
  localparam int BEAT_W = BYTE_W * BYTES
) (
  input  logic              clk,
  input  logic              rst_n,
  output logic              k_phase,
  input  logic              rd_n,
  input  logic [ADDR_W-1:0] rd_addr,
  input  logic              wr_n,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [BEAT_W-1:0] din,
  input  logic [BYTES-1:0]  bw_n,
  output logic [BEAT_W-1:0] dout,
  output logic              dout_valid
);
  kphase_e                phase;
  logic                   wr_stb;
  logic [ADDR_W-1:0]      wr_word_addr;
  logic [2*BEAT_W-1:0]    wr_word;
  logic [2*BYTES-1:0]     wr_be_n;
  logic [ADDR_W-1:0]      rd_word_addr;
  logic [2*BEAT_W-1:0]    rd_word;

  b2_phase_gen u_phase (
    .clk   (clk),
    .rst_n (rst_n),
    .phase (phase)
  );

  b2_write_demux #(.ADDR_W(ADDR_W), .BYTE_W(BYTE_W), .BYTES(BYTES)) u_wdemux (
    .clk          (clk),
    .rst_n        (rst_n),
    .phase        (phase),
    .wr_n         (wr_n),
    .wr_addr      (wr_addr),
    .din          (din),
    .bw_n         (bw_n),
    .wr_stb       (wr_stb),
    .wr_word_addr (wr_word_addr),
    .wr_word      (wr_word),
    .wr_be_n      (wr_be_n)
  );

  b2_array #(.ADDR_W(ADDR_W), .BYTE_W(BYTE_W), .BYTES(BYTES)) u_array (
    .clk   (clk),
    .rst_n (rst_n),
    .we    (wr_stb),
    .waddr (wr_word_addr),
    .wdata (wr_word),
    .wbe_n (wr_be_n),
    .raddr (rd_word_addr),
    .rdata (rd_word)
  );

  b2_read_mux #(.ADDR_W(ADDR_W), .BYTE_W(BYTE_W), .BYTES(BYTES)) u_rmux (
    .clk        (clk),
    .rst_n      (rst_n),
    .phase      (phase),
    .rd_n       (rd_n),
    .rd_addr    (rd_addr),
    .arr_addr   (rd_word_addr),
    .arr_word   (rd_word),
    .dout       (dout),
    .dout_valid (dout_valid)
  );

  assign k_phase = (phase == PH_KB);

  // R1: array writes happen only on K# edges
  assert_write_on_kb_R1: assert property (@(posedge clk) disable iff (!rst_n)
    wr_stb |-> k_phase);
endmodule

// File: tb/sep_io_b2_ram_test.sv
module sep_io_b2_ram_test;
  localparam int AW = 3;
  localparam int BW = 8;
  localparam int NB = 2;
  localparam int W  = BW * NB;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          k_phase;
  logic          rd_n = 1'b1;
  logic [AW-1:0] rd_addr = '0;
  logic          wr_n = 1'b1;
  logic [AW-1:0] wr_addr = '0;
  logic [W-1:0]  din = '0;
  logic [NB-1:0] bw_n = '1;
  logic [W-1:0]  dout;
  logic          dout_valid;

  int checks = 0;
  int errors = 0;

  logic [W-1:0] model [0:(1<<AW)-1][0:1];
  bit           p1v = 0, p2v = 0;
  logic [W-1:0] p1lo = '0, p1hi = '0, p2hi = '0;

  always #2 clk = ~clk;

  sep_io_b2_ram #(.ADDR_W(AW), .BYTE_W(BW), .BYTES(NB)) uut (
    .clk(clk), .rst_n(rst_n), .k_phase(k_phase), .rd_n(rd_n), .rd_addr(rd_addr),
    .wr_n(wr_n), .wr_addr(wr_addr), .din(din), .bw_n(bw_n),
    .dout(dout), .dout_valid(dout_valid)
  );

  task automatic chk(input bit ok, input string tag, input logic [31:0] act,
                     input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [W-1:0] apply_mask(input logic [W-1:0] old_b,
                                              input logic [W-1:0] new_b,
                                              input logic [NB-1:0] be_n);
    logic [W-1:0] r;
    for (int k = 0; k < W; k++) r[k] = be_n[k / BW] ? old_b[k] : new_b[k];
    return r;
  endfunction

  // One K period; entered and left at a negedge of a phase-0 cycle.
  // Phase-1 cycles drive rd_n/wr_n low to confirm they are ignored (R2, R5),
  // phase-0 cycles drive a wrong wr_addr to confirm it is ignored (R5).
  task automatic kcycle(input string tg, input bit rd, input logic [AW-1:0] ra,
                        input bit wr, input logic [AW-1:0] wa,
                        input logic [W-1:0] d0, input logic [W-1:0] d1,
                        input logic [NB-1:0] b0, input logic [NB-1:0] b1);
    logic [W-1:0] e_hi;
    e_hi = p2v ? p2hi : '0;
    chk(k_phase == 1'b0, {tg, " R1 phase0"}, 32'(k_phase), 32'(0));
    chk(dout_valid == p2v, {tg, " R4 valid beat1"}, 32'(dout_valid), 32'(p2v));
    chk(dout == e_hi, {tg, " R3 beat1"}, 32'(dout), 32'(e_hi));
    rd_n = !rd; rd_addr = ra; wr_n = !wr; wr_addr = ~wa; din = d0; bw_n = b0;
    @(posedge clk); @(negedge clk);
    e_hi = p1v ? p1lo : '0;
    chk(k_phase == 1'b1, {tg, " R1 phase1"}, 32'(k_phase), 32'(1));
    chk(dout_valid == p1v, {tg, " R4 valid beat0"}, 32'(dout_valid), 32'(p1v));
    chk(dout == e_hi, {tg, " R3 beat0"}, 32'(dout), 32'(e_hi));
    rd_n = 1'b0; rd_addr = ~ra; wr_n = 1'b0; wr_addr = wa; din = d1; bw_n = b1;
    if (wr) begin
      model[wa][0] = apply_mask(model[wa][0], d0, b0);
      model[wa][1] = apply_mask(model[wa][1], d1, b1);
    end
    p2v = p1v; p2hi = p1hi;
    p1v = rd; p1lo = model[ra][0]; p1hi = model[ra][1];
    @(posedge clk); @(negedge clk);
  endtask

  function automatic logic [W-1:0] pat(input int a, input int beat, input int salt);
    return W'((a * 16'h1357 + beat * 16'h0f0f + salt * 16'h2468) ^ 16'h5a5a);
  endfunction

  initial begin
    repeat (3) @(negedge clk);
    // R1 / R4 reset state
    chk(k_phase == 1'b0, "R1 reset phase", 32'(k_phase), 32'(0));
    chk(dout_valid == 1'b0, "R4 reset valid", 32'(dout_valid), 32'(0));
    chk(dout == '0, "R4 reset dout", 32'(dout), 32'(0));
    rst_n = 1'b1;

    // Fill: write a, read a in the same K period (R9, R6)
    for (int a = 0; a < (1 << AW); a++)
      kcycle("R9 fill", 1'b1, AW'(a), 1'b1, AW'(a), pat(a, 0, 0), pat(a, 1, 0), '0, '0);

    // Back-to-back reads, unbroken stream (R10, R6)
    for (int a = 0; a < (1 << AW); a++)
      kcycle("R10 stream", 1'b1, AW'(a), 1'b0, '0, '0, '0, '1, '1);

    // Read and write together at different addresses (R8)
    for (int a = 0; a < (1 << AW); a++)
      kcycle("R8 dual", 1'b1, AW'(a + 3), 1'b1, AW'(a), pat(a, 0, 1), pat(a, 1, 1), '0, '0);

    // Byte-enable sweep with read in the following period (R7, R9)
    for (int a = 0; a < (1 << AW); a++)
      for (int m = 0; m < (1 << (2 * NB)); m++) begin
        kcycle("R7 mask", 1'b0, '0, 1'b1, AW'(a), pat(a, 0, m + 2), pat(a, 1, m + 2),
               NB'(m), NB'(m >> NB));
        kcycle("R9 next", 1'b1, AW'(a), 1'b0, '0, '0, '0, '1, '1);
      end

    // Mixed traffic
    for (int i = 0; i < 300; i++)
      kcycle("R5 mix", 1'($urandom), AW'($urandom), 1'($urandom), AW'($urandom),
             W'($urandom), W'($urandom), NB'($urandom), NB'($urandom));

    // Drain: deselect cycles (R2, R4)
    repeat (3) kcycle("R2 idle", 1'b0, '0, 1'b0, '0, '0, '0, '1, '1);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(4 * 100000);
    checks++;
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule